// File: doc/BRIEF.md
# BCH8 Error Location Mapper

This block sits behind an 8-bit-correcting BCH decoder on a NAND read path. It handles one sector at a time. The codeword is 512 data bytes followed by 14 ECC bytes, and the last ECC byte is reserved. The block takes in the computed ECC, the ECC read back from flash, and the decoder's list of error bit locations. It then turns each reported location into a single bit flip, aimed either at the data buffer or at one of the stored ECC bytes.

A pulse on `start_i` captures the whole job. At that same edge the block screens the sector and goes straight to a finish if any of these holds: the computed ECC is all zero (clean sector), the stored ECC is all 0xFF (erased page), or the decoder marked the sector uncorrectable. Otherwise it walks the location list one entry per clock. For each entry it shows a flip command on its outputs for that cycle. A location that falls outside the codeword raises an error flag, and the walk goes on with the next entry.

At the same start edge the block also registers a syndrome image for the decoder. This is the computed ECC bytes in reversed order, followed by a zero reserved byte. When the walk ends, a one-cycle done pulse marks it. The count of corrections and the error flag then hold until the next job starts.

Top module: `bch_loc_mapper`

## Requirements
- R1: After reset, busy_o, done_o, flip_valid_o, err_o, clean_o and erased_o are low, and corr_count_o and syn_o are zero.
- R2: start_i is accepted only when busy_o is low. A start_i pulse while busy_o is high changes neither the job in flight nor syn_o.
- R3: At an accepted start, syn_o byte k (bits 8k+7:8k) takes computed byte 12−k for k in 0..12, and syn_o byte 13 is zero. Computed byte j arrives on calc_ecc_i bits 8j+7:8j.
- R4: If all 13 computed bytes are zero, the job is clean. clean_o is set, no flip is issued, and done_o is high in the cycle after the start edge.
- R5: If the job is not clean and all 14 stored bytes (stored_ecc_i byte j on bits 8j+7:8j) are 0xFF, erased_o is set, no flip is issued, and done_o comes the cycle after start.
- R6: If the job is neither clean nor erased and uncorr_i is high at start, err_o is set, no flip is issued, and done_o comes the cycle after start.
- R7: Otherwise entries 0..n−1 of loc_i (entry i on bits 13i+12:13i) are shown in order, one per cycle, starting the cycle after start. n is loc_cnt_i clamped to 8. done_o pulses for one cycle right after the last entry, or in the cycle after start when n is 0.
- R8: For location L, the byte position is 524 − floor(L/8) and flip_bit_o is L mod 8.
- R9: A byte position of 0..511 gives flip_valid_o high, flip_in_ecc_o low, and flip_byte_o equal to the position.
- R10: A byte position of 512..524 gives flip_valid_o high, flip_in_ecc_o high, and flip_byte_o equal to position − 512.
- R11: A location with floor(L/8) > 524 gives flip_valid_o low in its cycle and sets err_o, and the remaining entries are still processed.
- R12: corr_count_o is the number of valid flips in the job, but reads zero whenever err_o is high. It holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Job start pulse |
| uncorr_i | input | 1 | Decoder marks sector uncorrectable |
| loc_cnt_i | input | 4 | Number of reported locations |
| loc_i | input | 104 | Eight 13-bit bit locations |
| calc_ecc_i | input | 104 | Computed ECC, 13 bytes |
| stored_ecc_i | input | 112 | ECC read from flash, 14 bytes |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| flip_valid_o | output | 1 | Flip command valid this cycle |
| flip_in_ecc_o | output | 1 | Flip targets stored ECC (1) or data (0) |
| flip_byte_o | output | 9 | Byte index within the target area |
| flip_bit_o | output | 3 | Bit index within the byte |
| syn_o | output | 112 | Reordered syndrome image |
| clean_o | output | 1 | Last job was clean |
| erased_o | output | 1 | Last job was an erased page |
| err_o | output | 1 | Uncorrectable or invalid location seen |
| corr_count_o | output | 4 | Valid flips in last job |

## Verification
The bench builds the block with its default parameters: 512 data bytes, 14 ECC bytes, eight locations and 13-bit locations. With these values the whole 13-bit location space can be driven. That covers both ends of the data area (locations 104 and 4199), both ends of the ECC area (locations 0 and 103), and the invalid region from 4200 up to 8191. It also makes an oversized count of 12 possible, which exercises the clamp to eight.

// File: rtl/bch_map_pkg.sv
package bch_map_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_DONE = 2'd2
  } walk_st_e;
endpackage

// File: rtl/bch_syn_prep.sv
module bch_syn_prep #(
  parameter int ECC_BYTES = 14
) (
  input  logic [(ECC_BYTES-1)*8-1:0] calc_i,
  input  logic [ECC_BYTES*8-1:0]     stored_i,
  output logic [ECC_BYTES*8-1:0]     syn_o,
  output logic                       clean_o,
  output logic                       all_ff_o
);
  localparam int USED = ECC_BYTES - 1;

  for (genvar g = 0; g < USED; g++) begin : g_rev
    assign syn_o[g*8 +: 8] = calc_i[(USED-1-g)*8 +: 8];
  end
  assign syn_o[USED*8 +: 8] = 8'h00;

  assign clean_o  = (calc_i == '0);
  assign all_ff_o = &stored_i;
endmodule

// File: rtl/bch_loc_decode.sv
module bch_loc_decode #(
  parameter int DATA_BYTES = 512,
  parameter int ECC_BYTES  = 14,
  parameter int LOC_W      = 13,
  parameter int BYTE_W     = 9
) (
  input  logic [LOC_W-1:0]  loc_i,
  output logic              valid_o,
  output logic              in_ecc_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [2:0]        bit_o
);
  // highest usable byte position; reserved ECC byte excluded
  localparam int LAST_POS = DATA_BYTES + ECC_BYTES - 2;

  logic [LOC_W-1:0] q;
  logic [LOC_W-1:0] pos;

  assign q        = {3'b000, loc_i[LOC_W-1:3]};
  assign pos      = LOC_W'(LAST_POS) - q;
  assign valid_o  = (q <= LOC_W'(LAST_POS));
  assign in_ecc_o = (pos >= LOC_W'(DATA_BYTES));
  assign byte_o   = in_ecc_o ? BYTE_W'(pos - LOC_W'(DATA_BYTES)) : BYTE_W'(pos);
  assign bit_o    = loc_i[2:0];
endmodule

// File: rtl/bch_walk_ctrl.sv
module bch_walk_ctrl
  import bch_map_pkg::*;
#(
  parameter int DATA_BYTES = 512,
  parameter int ECC_BYTES  = 14,
  parameter int MAX_ERR    = 8,
  parameter int LOC_W      = 13,
  parameter int BYTE_W     = 9,
  parameter int CNT_W      = 4,
  parameter int IDX_W      = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     uncorr_i,
  input  logic                     clean_i,
  input  logic                     all_ff_i,
  input  logic [CNT_W-1:0]         loc_cnt_i,
  input  logic [MAX_ERR*LOC_W-1:0] loc_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     flip_valid_o,
  output logic                     flip_in_ecc_o,
  output logic [BYTE_W-1:0]        flip_byte_o,
  output logic [2:0]               flip_bit_o,
  output logic                     clean_o,
  output logic                     erased_o,
  output logic                     err_o,
  output logic [CNT_W-1:0]         corr_count_o
);
  walk_st_e         st_q;
  logic [LOC_W-1:0] locs_q [MAX_ERR];
  logic [CNT_W-1:0] n_q, cnt_q, n_in;
  logic [IDX_W-1:0] idx_q;
  logic             err_q, clean_q, erased_q;
  logic             dec_valid;
  logic             erased_in, early_in, last_entry;

  assign n_in      = (loc_cnt_i > CNT_W'(MAX_ERR)) ? CNT_W'(MAX_ERR) : loc_cnt_i;
  assign erased_in = !clean_i && all_ff_i;
  assign early_in  = clean_i || all_ff_i || uncorr_i || (n_in == '0);
  assign last_entry = (CNT_W'(idx_q) == n_q - CNT_W'(1));

  bch_loc_decode #(
    .DATA_BYTES(DATA_BYTES),
    .ECC_BYTES (ECC_BYTES),
    .LOC_W     (LOC_W),
    .BYTE_W    (BYTE_W)
  ) u_dec (
    .loc_i   (locs_q[idx_q]),
    .valid_o (dec_valid),
    .in_ecc_o(flip_in_ecc_o),
    .byte_o  (flip_byte_o),
    .bit_o   (flip_bit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      n_q      <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      err_q    <= 1'b0;
      clean_q  <= 1'b0;
      erased_q <= 1'b0;
      for (int k = 0; k < MAX_ERR; k++) locs_q[k] <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          for (int k = 0; k < MAX_ERR; k++) locs_q[k] <= loc_i[k*LOC_W +: LOC_W];
          n_q      <= n_in;
          idx_q    <= '0;
          cnt_q    <= '0;
          clean_q  <= clean_i;
          erased_q <= erased_in;
          err_q    <= uncorr_i && !clean_i && !all_ff_i;
          st_q     <= early_in ? ST_DONE : ST_WALK;
        end
        ST_WALK: begin
          if (dec_valid) cnt_q <= cnt_q + CNT_W'(1);
          else           err_q <= 1'b1;
          idx_q <= idx_q + IDX_W'(1);
          if (last_entry) st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_DONE);
  assign flip_valid_o = (st_q == ST_WALK) && dec_valid;
  assign clean_o      = clean_q;
  assign erased_o     = erased_q;
  assign err_o        = err_q;
  assign corr_count_o = err_q ? '0 : cnt_q;
endmodule

// File: rtl/bch_loc_mapper.sv
module bch_loc_mapper #(
  parameter int DATA_BYTES = 512,
  parameter int ECC_BYTES  = 14,
  parameter int MAX_ERR    = 8,
  parameter int LOC_W      = 13,
  localparam int BYTE_W    = $clog2(DATA_BYTES),
  localparam int CNT_W     = $clog2(MAX_ERR + 1),
  localparam int IDX_W     = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         uncorr_i,
  input  logic [CNT_W-1:0]             loc_cnt_i,
  input  logic [MAX_ERR*LOC_W-1:0]     loc_i,
  input  logic [(ECC_BYTES-1)*8-1:0]   calc_ecc_i,
  input  logic [ECC_BYTES*8-1:0]       stored_ecc_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         flip_valid_o,
  output logic                         flip_in_ecc_o,
  output logic [BYTE_W-1:0]            flip_byte_o,
  output logic [2:0]                   flip_bit_o,
  output logic [ECC_BYTES*8-1:0]       syn_o,
  output logic                         clean_o,
  output logic                         erased_o,
  output logic                         err_o,
  output logic [CNT_W-1:0]             corr_count_o
);
  logic [ECC_BYTES*8-1:0] syn_d, syn_q;
  logic                   clean_w, all_ff_w;

  bch_syn_prep #(.ECC_BYTES(ECC_BYTES)) u_prep (
    .calc_i  (calc_ecc_i),
    .stored_i(stored_ecc_i),
    .syn_o   (syn_d),
    .clean_o (clean_w),
    .all_ff_o(all_ff_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 syn_q <= '0;
    else if (start_i && !busy_o) syn_q <= syn_d;
  end
  assign syn_o = syn_q;

  bch_walk_ctrl #(
    .DATA_BYTES(DATA_BYTES),
    .ECC_BYTES (ECC_BYTES),
    .MAX_ERR   (MAX_ERR),
    .LOC_W     (LOC_W),
    .BYTE_W    (BYTE_W),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
  ) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .uncorr_i     (uncorr_i),
    .clean_i      (clean_w),
    .all_ff_i     (all_ff_w),
    .loc_cnt_i    (loc_cnt_i),
    .loc_i        (loc_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .flip_valid_o (flip_valid_o),
    .flip_in_ecc_o(flip_in_ecc_o),
    .flip_byte_o  (flip_byte_o),
    .flip_bit_o   (flip_bit_o),
    .clean_o      (clean_o),
    .erased_o     (erased_o),
    .err_o        (err_o),
    .corr_count_o (corr_count_o)
  );
endmodule

// File: rtl/bch_loc_mapper_chk.sv
module bch_loc_mapper_chk #(
  parameter int ECC_BYTES = 14,
  parameter int MAX_ERR   = 8,
  parameter int BYTE_W    = 9,
  parameter int CNT_W     = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   flip_valid_o,
  input logic                   flip_in_ecc_o,
  input logic [BYTE_W-1:0]      flip_byte_o,
  input logic [ECC_BYTES*8-1:0] syn_o,
  input logic                   clean_o,
  input logic                   erased_o,
  input logic [CNT_W-1:0]       corr_count_o
);
  AST_BUSY_START_NO_SYN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(syn_o)); // R2
  AST_EARLY_NO_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clean_o || erased_o) |-> !flip_valid_o); // R4 R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_FLIP_IN_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_valid_o |-> (busy_o && !done_o)); // R7
  AST_ECC_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_valid_o && flip_in_ecc_o) |-> (flip_byte_o < BYTE_W'(ECC_BYTES - 1))); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_count_o <= CNT_W'(MAX_ERR)); // R12
endmodule

bind bch_loc_mapper bch_loc_mapper_chk #(
  .ECC_BYTES(ECC_BYTES),
  .MAX_ERR  (MAX_ERR),
  .BYTE_W   (BYTE_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .flip_valid_o (flip_valid_o),
  .flip_in_ecc_o(flip_in_ecc_o),
  .flip_byte_o  (flip_byte_o),
  .syn_o        (syn_o),
  .clean_o      (clean_o),
  .erased_o     (erased_o),
  .corr_count_o (corr_count_o)
);

// File: tb/bch_loc_mapper_tb.sv
module bch_loc_mapper_tb;
  localparam int NE = 8;
  localparam int LW = 13;
  localparam int EB = 14;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             uncorr_i = 1'b0;
  logic [3:0]       loc_cnt_i = '0;
  logic [NE*LW-1:0] loc_i = '0;
  logic [103:0]     calc_ecc_i = '0;
  logic [111:0]     stored_ecc_i = '0;
  logic             busy_o, done_o, flip_valid_o, flip_in_ecc_o;
  logic [8:0]       flip_byte_o;
  logic [2:0]       flip_bit_o;
  logic [111:0]     syn_o;
  logic             clean_o, erased_o, err_o;
  logic [3:0]       corr_count_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int calc_b [13];
  int stor_b [14];
  int locs [NE];

  always #5 clk_i = ~clk_i;

  bch_loc_mapper u_dut (
    .clk_i, .rst_ni, .start_i, .uncorr_i, .loc_cnt_i, .loc_i, .calc_ecc_i,
    .stored_ecc_i, .busy_o, .done_o, .flip_valid_o, .flip_in_ecc_o,
    .flip_byte_o, .flip_bit_o, .syn_o, .clean_o, .erased_o, .err_o, .corr_count_o
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_vec(string req, string what, logic [111:0] act, logic [111:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural location model
  task automatic ref_loc(int l, output bit v, output bit in_ecc, output int byt, output int bitn);
    int pos;
    pos = 524 - l / 8;
    bitn = l % 8;
    v = (pos >= 0);
    in_ecc = (pos >= 512);
    byt = in_ecc ? pos - 512 : pos;
  endtask

  task automatic run_job(string tag, int n, bit unc, bit poke);
    bit clean, erased, early, e_err;
    int neff, cnt;
    logic [111:0] exp_syn;
    logic [103:0] cv;
    cv = '0;
    for (int j = 0; j < 13; j++) cv[j*8 +: 8] = 8'(calc_b[j]);
    @(negedge clk_i);
    calc_ecc_i = cv;
    for (int j = 0; j < 14; j++) stored_ecc_i[j*8 +: 8] = 8'(stor_b[j]);
    for (int j = 0; j < NE; j++) loc_i[j*LW +: LW] = LW'(locs[j]);
    loc_cnt_i = 4'(n);
    uncorr_i = unc;
    start_i = 1'b1;
    clean = 1;
    for (int j = 0; j < 13; j++) if (calc_b[j] != 0) clean = 0;
    erased = !clean;
    for (int j = 0; j < 14; j++) if (stor_b[j] != 8'hFF) erased = 0;
    neff = (n > NE) ? NE : n;
    e_err = unc && !clean && !erased;
    early = clean || erased || unc || neff == 0;
    exp_syn = '0;
    for (int k = 0; k < 13; k++) exp_syn[k*8 +: 8] = 8'(calc_b[12-k]);
    cnt = 0;
    @(negedge clk_i);
    if (poke) begin
      start_i = 1'b1;
      loc_cnt_i = 4'd1;
      calc_ecc_i = ~cv;
    end else start_i = 1'b0;
    if (!early) begin
      for (int k = 0; k < neff; k++) begin
        bit v, ie;
        int b, bi;
        if (k == 1) start_i = 1'b0;
        ref_loc(locs[k], v, ie, b, bi);
        chk("R7", {tag, " done during walk"}, int'(done_o), 0);
        chk(v ? "R9" : "R11", {tag, " flip_valid"}, int'(flip_valid_o), int'(v));
        if (v) begin
          chk(ie ? "R10" : "R9", {tag, " in_ecc"}, int'(flip_in_ecc_o), int'(ie));
          chk("R8", {tag, " byte"}, int'(flip_byte_o), b);
          chk("R8", {tag, " bit"}, int'(flip_bit_o), bi);
          cnt++;
        end else e_err = 1;
        @(negedge clk_i);
      end
    end else begin
      chk("R4", {tag, " no flip on early exit"}, int'(flip_valid_o), 0);
    end
    start_i = 1'b0;
    chk("R7", {tag, " done pulse"}, int'(done_o), 1);
    chk("R12", {tag, " corr_count"}, int'(corr_count_o), e_err ? 0 : cnt);
    chk("R11", {tag, " err"}, int'(err_o), int'(e_err));
    chk("R4", {tag, " clean"}, int'(clean_o), int'(clean));
    chk("R5", {tag, " erased"}, int'(erased_o), int'(erased));
    chk_vec("R3", {tag, " syndrome"}, syn_o, exp_syn);
    @(negedge clk_i);
    chk("R7", {tag, " done falls"}, int'(done_o), 0);
    chk("R2", {tag, " idle after job"}, int'(busy_o), 0);
    chk("R12", {tag, " count held"}, int'(corr_count_o), e_err ? 0 : cnt);
  endtask

  task automatic set_calc(int seed);
    for (int j = 0; j < 13; j++) calc_b[j] = (seed + j * 37) & 8'hFF;
  endtask

  task automatic set_stor(int val);
    for (int j = 0; j < 14; j++) stor_b[j] = val;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int j = 0; j < NE; j++) locs[j] = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "flip_valid", int'(flip_valid_o), 0);
    chk("R1", "err", int'(err_o), 0);
    chk("R1", "clean", int'(clean_o), 0);
    chk("R1", "erased", int'(erased_o), 0);
    chk("R1", "count", int'(corr_count_o), 0);
    chk_vec("R1", "syn", syn_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 clean sector, locations present but unused
    for (int j = 0; j < 13; j++) calc_b[j] = 0;
    set_stor(8'h12);
    locs[0] = 40; locs[1] = 41; locs[2] = 42;
    run_job("clean", 3, 1'b1, 1'b0);

    // R5 erased page
    set_calc(7);
    set_stor(8'hFF);
    run_job("erased", 3, 1'b0, 1'b0);

    // R6 uncorrectable; stored almost all 0xFF so not erased
    set_calc(99);
    set_stor(8'hFF);
    stor_b[13] = 8'hFE;
    run_job("uncorr", 3, 1'b1, 1'b0);

    // R8 R9 R10 boundaries
    set_calc(3);
    set_stor(8'h5A);
    locs[0] = 0; locs[1] = 103; locs[2] = 104; locs[3] = 4199; locs[4] = 1000;
    locs[5] = 5;
    run_job("bounds", 6, 1'b0, 1'b0);

    // R11 invalid locations mid list, processing continues
    locs[0] = 4200; locs[1] = 50; locs[2] = 8191; locs[3] = 300;
    run_job("invalid", 4, 1'b0, 1'b0);

    // R7 count clamp
    for (int j = 0; j < NE; j++) locs[j] = 17 + j * 511;
    run_job("clamp", 12, 1'b0, 1'b0);

    // R7 zero count
    run_job("zero", 0, 1'b0, 1'b0);

    // R2 start while busy ignored
    set_calc(201);
    locs[0] = 2000; locs[1] = 80; locs[2] = 4100; locs[3] = 9;
    run_job("busy_start", 4, 1'b0, 1'b1);

    summary();
  end
endmodule